// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Event Line Controller

This block watches twenty input lines for level changes and turns them into interrupt requests and event pulses. Every line has its own pair of edge enables, one for rising and one for falling, and both may be active together. An edge that is enabled on a line whose interrupt mask is set records a sticky pending flag. The flag drives that line's interrupt output until software writes a one to clear it. The same edge, if the line's event mask is set, also produces a single-cycle pulse on a shared event output. The event path never touches the pending flags.

Edges are caught asynchronously. Each line clocks a pair of toggle flops directly, one on its rising edge and one on its falling edge. A two-flop synchronizer then carries each toggle into the bus clock domain. A pulse shorter than one bus clock still leaves a trace this way. The lowest sixteen lines come from a port multiplexer: line n takes pin n of the port named by its 4-bit selector. The upper four lines come straight from dedicated inputs. Software can also force pending flags through a trigger register.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq_out` is all zero and `evt_out` is low.
- R2: A rising transition on a line with its rising enable and interrupt mask set makes its pending bit, and its `irq_out` bit, read 1 from the third rising clock edge after the transition. The transition lands between edges, and the synchronizer takes two clocks.
- R3: The falling enable works the same way for falling transitions. With both enables set, each direction sets the pending bit on its own.
- R4: A high or low pulse shorter than one clock period on a line registers both of its edges. Each enabled direction sets pending as in R2.
- R5: A transition whose direction is not enabled on that line sets no pending bit and produces no event.
- R6: An enabled edge sets pending only if the line's interrupt mask is 1. `irq_out[n]` is the pending bit ANDed with the interrupt mask.
- R7: Writing the pending register (word 5) clears the bits written as 1 and leaves the bits written as 0 unchanged. A hardware set at the same clock edge as a clear wins, and the bit stays 1.
- R8: Writing 1s to the trigger register (word 4) sets those pending bits at that clock edge without raising `evt_out`. Word 4 always reads 0.
- R9: `evt_out` is high for one clock, in the cycle an enabled edge is detected, when that line's event mask is 1. This is the cycle before the matching pending bit would appear.
- R10: Line n (n < 16) follows bit `p*16+n` of `gpio_in`, where p is its selector value. A selector value of 4 or more holds the line low. Lines 16 to 19 follow `aux_in[0..3]`. A selector change that moves the line's level counts as an edge.
- R11: Word map, with bit n belonging to line n. Word 0 is the interrupt mask, 1 the event mask, 2 the rising enables, 3 the falling enables, 4 the trigger and 5 pending. Word 6 holds the selectors of lines 0 to 7, and word 7 those of lines 8 to 15, four bits per line with line 8k+i at bits 4i+3:4i. Writes take effect at the clock edge, and reads are combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_in | input | NPORTS*NGPIO (64) | Port pins, port p pin n at bit p*NGPIO+n |
| aux_in | input | NLINES-NGPIO (4) | Direct inputs for lines 16 and up |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_out | output | NLINES (20) | Per-line interrupt request |
| evt_out | output | 1 | Event pulse |

## Verification
The bench builds the block with its defaults: 20 lines, 16 multiplexed lines and 4 ports. Selector values 4 to 15 therefore exist but name no port, which reaches the held-low case of R10. With 4 direct lines, the aux inputs are tested alongside the multiplexed ones. Sub-cycle pulses, selector-induced edges and a clear that lands on the same clock as a hardware set are driven both as directed cases and in a randomized run against the behavioural model.

// File: rtl/edge_irq_ctrl.sv
`timescale 1ns/1ps
module edge_irq_ctrl #(
  parameter int NLINES = 20,
  parameter int NGPIO  = 16,
  parameter int NPORTS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPORTS*NGPIO-1:0]   gpio_in,
  input  logic [NLINES-NGPIO-1:0]   aux_in,
  input  logic                      reg_we,
  input  logic [2:0]                reg_addr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  output logic [NLINES-1:0]         irq_out,
  output logic                      evt_out
);
  localparam int SELW = 4;
  localparam int NSEL = 1 << SELW;
  localparam int PER_WORD = 32 / SELW;

  logic [NLINES-1:0] imask_q, emask_q, ren_q, fen_q, pend_q;
  logic [NGPIO*SELW-1:0] psel_q;
  logic [NLINES-1:0] line_w, rtog, ftog;
  logic [NLINES-1:0] rs1, rs2, rs3, fs1, fs2, fs3;
  logic [NLINES-1:0] trig, set_vec, clr_vec;
  logic [63:0] psel_pad;

  for (genvar n = 0; n < NGPIO; n++) begin : g_mux
    logic [NSEL-1:0] col;
    for (genvar p = 0; p < NSEL; p++) begin : g_col
      if (p < NPORTS) begin : g_port
        assign col[p] = gpio_in[p*NGPIO + n];
      end else begin : g_none
        assign col[p] = 1'b0;
      end
    end
    assign line_w[n] = col[psel_q[n*SELW +: SELW]];
  end

  for (genvar n = NGPIO; n < NLINES; n++) begin : g_aux
    assign line_w[n] = aux_in[n-NGPIO];
  end

  for (genvar n = 0; n < NLINES; n++) begin : g_cap
    logic rt, ft;
    always_ff @(posedge line_w[n] or negedge rst_n)
      if (!rst_n) rt <= 1'b0;
      else        rt <= ~rt;
    always_ff @(negedge line_w[n] or negedge rst_n)
      if (!rst_n) ft <= 1'b0;
      else        ft <= ~ft;
    assign rtog[n] = rt;
    assign ftog[n] = ft;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {rs1, rs2, rs3} <= '0;
      {fs1, fs2, fs3} <= '0;
    end else begin
      rs1 <= rtog; rs2 <= rs1; rs3 <= rs2;
      fs1 <= ftog; fs2 <= fs1; fs3 <= fs2;
    end

  assign trig    = ((rs2 ^ rs3) & ren_q) | ((fs2 ^ fs3) & fen_q);
  assign set_vec = (trig & imask_q) |
                   ((reg_we && reg_addr == 3'd4) ? reg_wdata[NLINES-1:0] : '0);
  assign clr_vec = (reg_we && reg_addr == 3'd5) ? reg_wdata[NLINES-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      imask_q <= '0; emask_q <= '0; ren_q <= '0; fen_q <= '0;
      pend_q  <= '0; psel_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_vec) | set_vec;
      if (reg_we) begin
        case (reg_addr)
          3'd0: imask_q <= reg_wdata[NLINES-1:0];
          3'd1: emask_q <= reg_wdata[NLINES-1:0];
          3'd2: ren_q   <= reg_wdata[NLINES-1:0];
          3'd3: fen_q   <= reg_wdata[NLINES-1:0];
          default: ;
        endcase
        for (int n = 0; n < NGPIO; n++)
          if (reg_addr == 3'(6 + n / PER_WORD))
            psel_q[n*SELW +: SELW] <= reg_wdata[(n % PER_WORD)*SELW +: SELW];
      end
    end

  assign psel_pad = 64'(psel_q);
  assign irq_out  = pend_q & imask_q;
  assign evt_out  = |(trig & emask_q);

  always_comb
    case (reg_addr)
      3'd0:    reg_rdata = 32'(imask_q);
      3'd1:    reg_rdata = 32'(emask_q);
      3'd2:    reg_rdata = 32'(ren_q);
      3'd3:    reg_rdata = 32'(fen_q);
      3'd5:    reg_rdata = 32'(pend_q);
      3'd6:    reg_rdata = psel_pad[31:0];
      3'd7:    reg_rdata = psel_pad[63:32];
      default: reg_rdata = 32'd0;
    endcase

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((pend_q & $past(clr_vec & ~set_vec)) == '0));
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~$past(pend_q) & ~$past(set_vec)) == '0);
  p_swtrig_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd4) |=>
      ((pend_q & $past(reg_wdata[NLINES-1:0])) == $past(reg_wdata[NLINES-1:0])));
endmodule

// File: tb/sim_edge_irq_ctrl.sv
`timescale 1ns/1ps
module sim_edge_irq_ctrl;
  localparam int NL = 20, NG = 16, NP = 4;
  localparam bit [NL-1:0] ALL = '1;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [NP*NG-1:0] gpio_in = '0;
  logic [NL-NG-1:0] aux_in = '0;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  wire  [31:0] reg_rdata;
  wire  [NL-1:0] irq_out;
  wire  evt_out;

  edge_irq_ctrl #(.NLINES(NL), .NGPIO(NG), .NPORTS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .aux_in(aux_in),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out), .evt_out(evt_out));

  bit [NL-1:0] m_im, m_em, m_re, m_fe, m_pend;
  bit [NL-1:0] r0r, r0f, d1r, d1f, d2r, d2f, lv_prev;
  int m_psel [NG];
  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit [2:0] rd_addr = 3'd5;
  bit done = 0;

  function automatic bit [NL-1:0] levels(bit [NP*NG-1:0] g, bit [NL-NG-1:0] a);
    bit [NL-1:0] l;
    for (int n = 0; n < NG; n++) l[n] = (m_psel[n] < NP) ? g[m_psel[n]*NG + n] : 1'b0;
    for (int n = NG; n < NL; n++) l[n] = a[n-NG];
    return l;
  endfunction

  function automatic bit [31:0] mread(bit [2:0] a);
    bit [31:0] v = 0;
    case (a)
      3'd0: v = 32'(m_im);
      3'd1: v = 32'(m_em);
      3'd2: v = 32'(m_re);
      3'd3: v = 32'(m_fe);
      3'd5: v = 32'(m_pend);
      3'd6: for (int i = 0; i < 8; i++) v[4*i +: 4] = 4'(m_psel[i]);
      3'd7: for (int i = 0; i < 8; i++) v[4*i +: 4] = 4'(m_psel[i+8]);
      default: v = 0;
    endcase
    return v;
  endfunction

  task automatic note(bit [NL-1:0] lv);
    r0r |= ~lv_prev & lv;
    r0f |= lv_prev & ~lv;
    lv_prev = lv;
  endtask

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit ev = |(((d2r & m_re) | (d2f & m_fe)) & m_em);
    chk("irq_out", 32'(irq_out), 32'(m_pend & m_im));
    chk("evt_out", 32'(evt_out), 32'(ev));
    chk("reg_rdata", reg_rdata, mread(reg_addr));
  endtask

  task automatic cyc(bit we, bit [2:0] a, bit [31:0] wd, bit pulse,
                     bit [NP*NG-1:0] gp, bit [NL-NG-1:0] ap,
                     bit [NP*NG-1:0] gf, bit [NL-NG-1:0] af);
    bit [NL-1:0] trig, setv, wv;
    @(negedge clk);
    compare();
    note(levels(gpio_in, aux_in));
    reg_we = we; reg_addr = we ? a : rd_addr; reg_wdata = wd;
    if (pulse) begin
      gpio_in = gp; aux_in = ap;
      #0.3;
      note(levels(gp, ap));
    end
    gpio_in = gf; aux_in = af;
    note(levels(gf, af));
    wv   = wd[NL-1:0];
    trig = (d2r & m_re) | (d2f & m_fe);
    setv = trig & m_im;
    if (we && a == 3'd4) setv |= wv;
    if (we && a == 3'd5) m_pend &= ~wv;
    m_pend |= setv;
    if (we)
      case (a)
        3'd0: m_im = wv;
        3'd1: m_em = wv;
        3'd2: m_re = wv;
        3'd3: m_fe = wv;
        3'd6: for (int i = 0; i < 8; i++) m_psel[i] = int'(wd[4*i +: 4]);
        3'd7: for (int i = 0; i < 8; i++) m_psel[i+8] = int'(wd[4*i +: 4]);
        default: ;
      endcase
    d2r = d1r; d2f = d1f; d1r = r0r; d1f = r0f; r0r = '0; r0f = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, '0, '0, gpio_in, aux_in);
  endtask
  task automatic wr(bit [2:0] a, bit [31:0] d);
    cyc(1, a, d, 0, '0, '0, gpio_in, aux_in);
  endtask
  task automatic setp(bit [NP*NG-1:0] g, bit [NL-NG-1:0] x);
    cyc(0, 0, 0, 0, '0, '0, g, x);
  endtask
  task automatic pls(bit [NP*NG-1:0] g, bit [NL-NG-1:0] x);
    cyc(0, 0, 0, 1, g, x, gpio_in, aux_in);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #750000;
    n_cmp++; n_bad++;
    $display("FAIL %s watchdog: actual running expected finished", cur_req);
    finish_run();
  end

  initial begin
    for (int i = 0; i < NG; i++) m_psel[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    cur_req = "R1";
    for (int a = 0; a < 8; a++) begin rd_addr = 3'(a); idle(1); end

    cur_req = "R11";
    wr(0, 32'h000FFFFF); wr(1, 32'h00012345); wr(2, 32'h000AAAAA); wr(3, 32'h00055555);
    wr(6, 32'h76543210); wr(7, 32'hFEDCBA98); wr(4, 32'h0);
    for (int a = 0; a < 8; a++) begin rd_addr = 3'(a); idle(1); end
    wr(6, 0); wr(7, 0); wr(1, 0);
    rd_addr = 3'd5;

    cur_req = "R2";
    wr(2, ALL); wr(3, 0);
    setp(gpio_in | 64'(1) << 3, aux_in);
    idle(5);

    cur_req = "R7";
    wr(5, 0); idle(1);
    wr(5, 32'(1) << 3); idle(2);

    cur_req = "R3";
    wr(2, 0); wr(3, ALL);
    setp(gpio_in & ~(64'(1) << 3), aux_in); idle(4); wr(5, ALL);
    wr(2, ALL);
    setp(gpio_in, aux_in | 4'b0010); idle(4); wr(5, ALL);
    setp(gpio_in, aux_in & ~4'b0010); idle(4); wr(5, ALL);

    cur_req = "R4";
    wr(3, 0);
    pls(gpio_in | 64'(1) << 5, aux_in); idle(4); wr(5, ALL);
    wr(2, 0); wr(3, ALL);
    pls(gpio_in | 64'(1) << 5, aux_in); idle(4); wr(5, ALL);
    setp(gpio_in, aux_in | 4'b1000); idle(4); wr(5, ALL);
    pls(gpio_in, aux_in & ~4'b1000); idle(4); wr(5, ALL);

    cur_req = "R5";
    wr(2, ALL & ~(NL'(1) << 6)); wr(3, ALL & ~(NL'(1) << 6)); wr(1, ALL);
    setp(gpio_in | 64'(1) << 6, aux_in); idle(4);
    setp(gpio_in & ~(64'(1) << 6), aux_in); idle(4);
    pls(gpio_in | 64'(1) << 6, aux_in); idle(4);
    wr(1, 0);

    cur_req = "R6";
    wr(2, ALL); wr(3, ALL);
    wr(0, ALL & ~(NL'(1) << 7)); wr(1, 32'(1) << 7);
    setp(gpio_in | 64'(1) << 7, aux_in); idle(4);
    wr(0, ALL); idle(2);

    cur_req = "R9";
    wr(1, 32'(1) << 8);
    pls(gpio_in | 64'(1) << 8, aux_in); idle(4); wr(5, ALL);
    wr(1, 0);
    setp(gpio_in | 64'(1) << 8, aux_in); idle(4); wr(5, ALL);

    cur_req = "R8";
    wr(1, ALL);
    wr(4, 32'h000F0F00); rd_addr = 3'd4; idle(2);
    rd_addr = 3'd5; idle(1); wr(5, ALL); wr(1, 0);

    cur_req = "R7";
    wr(2, 32'(1) << 9); wr(3, 0);
    setp(gpio_in | 64'(1) << 9, aux_in);
    idle(1);
    wr(5, 32'(1) << 9);
    idle(2);
    wr(5, ALL); idle(1);

    cur_req = "R10";
    wr(2, ALL); wr(3, ALL); wr(1, ALL);
    wr(6, 32'h00000200);
    setp(gpio_in | 64'(1) << 2, aux_in); idle(4);
    setp(gpio_in | 64'(1) << 34, aux_in); idle(4); wr(5, ALL);
    wr(6, 32'h00000900); idle(4); wr(5, ALL);
    wr(6, 32'h00000000); idle(4); wr(5, ALL);
    wr(7, 32'h00000003);
    setp(gpio_in | 64'(1) << 56, aux_in); idle(4); wr(5, ALL);
    setp(gpio_in, aux_in ^ 4'b0100); idle(4); wr(5, ALL);

    cur_req = "R2";
    begin
      bit hold = 0;
      for (int i = 0; i < 1500; i++) begin
        int r = int'($urandom % 8);
        bit [63:0] m = {$urandom, $urandom} & {$urandom, $urandom};
        bit [3:0] ma = 4'($urandom);
        rd_addr = 3'($urandom % 8);
        if (hold) begin idle(1); hold = 0; end
        else if (r == 0) begin
          bit [2:0] a = 3'($urandom % 8);
          wr(a, $urandom);
          hold = (a >= 3'd6);
        end
        else if (r < 4) setp(gpio_in ^ m, aux_in ^ ma);
        else if (r < 6) pls(gpio_in ^ m, aux_in ^ ma);
        else idle(1);
      end
    end
    idle(6);
    finish_run();
  end
endmodule